// File: doc/BRIEF.md
# Rejected Interrupt Resend Scanner

This block remembers which interrupt sources the presentation controller turned away and plays them back when a resend command arrives. Each rejected source number sets one bit in a bitmap of 2048 bits, arranged as 32 words of 64 bits. A 32-bit summary sits above the bitmap, with one bit for each word that may hold pending entries. A resend therefore touches only the words that have something in them.

When a resend starts, the scanner takes the lowest marked summary bit whose word has not yet been visited and clears that summary bit. It then uses a find-first-set over the word, restricted to positions at or above the current scan position. This finds the next pending bit in one step. The bit is cleared and a retry for source `word*64 + bit` is presented on a valid/ready output. Every retry carries a flag that tells the downstream pending/queued gate to disregard its stored state. When no marked word remains, a one-cycle done pulse ends the scan.

Rejects can still arrive while a scan is running. A reject that lands ahead of the scan position is replayed in the same scan. A reject that lands behind it stays stored until the next resend command.

Top module: `resend_scanner`

## Requirements
- R1: A reject of source s (word index `s[10:6]`, bit index `s[5:0]`) is stored, and the next resend presents s as a retry exactly once.
- R2: A resend request while the summary is all zero raises `scanDone` on the first clock edge after the request, with no retry presented.
- R3: Within one scan, accepted retries appear in strictly ascending source number. Words are visited low to high, and bits within a word low to high.
- R4: Every source replayed by a scan is cleared. A second resend with no new rejects in between produces no retries.
- R5: `retryIgnore` is high whenever `retryValid` is high.
- R6: While `retryValid` is high and `retryReady` is low, `retryValid` stays high and `retrySrc` holds its value.
- R7: `scanDone` is a single-cycle pulse after the last retry of a scan is accepted. No retry is presented after it until the next resend request.
- R8: A reject that arrives during a scan, at a position above the one being scanned, is replayed in that scan. A reject at a position already passed is held for the next resend.
- R9: Several rejects of the same source before a resend produce a single retry.
- R10: A resend request that arrives while a scan is in progress is ignored. It does not restart the scan and does not add a second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rejValid | input | 1 | A source was rejected this cycle |
| rejSrc | input | 11 | Rejected source number |
| resendReq | input | 1 | Start a replay scan |
| retryValid | output | 1 | Retry available |
| retryReady | input | 1 | Downstream takes the retry |
| retrySrc | output | 11 | Source number to retry |
| retryIgnore | output | 1 | Retry must bypass stored pending/queued state |
| scanDone | output | 1 | One-cycle pulse at scan end |

## Verification
A wrong internal state shows up at the ports in a few ways. A summary bit or word bit that is not cleared appears as a repeated source on the next resend. A bit that fails to set appears as a missing source in the very next scan. A wrong scan position or wrong word pointer breaks the ascending order of the retry stream within a couple of cycles of the fault, or makes a late reject appear in the wrong scan. The sweeps load dense, strided and boundary patterns, replay them under backpressure, and compare every accepted retry with the next ascending source the bench expects.

// File: rtl/resend_scanner_pkg.sv
package resend_scanner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PICK  = 2'd1,
    ST_SCAN  = 2'd2,
    ST_ISSUE = 2'd3
  } scanState_e;

  // strobes from control to the bitmap datapath
  typedef struct packed {
    logic startScan;  // rewind word pointer
    logic pickWord;   // claim lowest marked word, clear its summary bit
    logic takeBit;    // latch lowest pending bit, clear it
    logic advance;    // move bit position past the issued bit
  } scanStrobe_t;

endpackage

// File: rtl/resend_bitmap.sv
module resend_bitmap
  import resend_scanner_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WIDX_W = $clog2(NUM_WORDS),
  localparam int BIT_W = $clog2(WORD_BITS),
  localparam int SRC_W = WIDX_W + BIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rejValid,
  input  logic [SRC_W-1:0] rejSrc,
  input  scanStrobe_t      strobe,
  output logic             sumAny,
  output logic             sumHit,
  output logic             wordHit,
  output logic             lastBit,
  output logic [SRC_W-1:0] retrySrc
);

  localparam int NXT_W = WIDX_W + 1;

  logic [NUM_WORDS-1:0]                sumBits;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] words;
  logic [NXT_W-1:0]                    nextWord;
  logic [WIDX_W-1:0]                   curWord;
  logic [BIT_W-1:0]                    scanPos;
  logic [BIT_W-1:0]                    srcBit;

  logic [WIDX_W-1:0] pickIdx;
  logic [BIT_W-1:0]  hitBit;
  logic [WIDX_W-1:0] rejWord;
  logic [BIT_W-1:0]  rejBit;
  logic [WORD_BITS-1:0] curRow;

  assign rejWord = rejSrc[SRC_W-1:BIT_W];
  assign rejBit  = rejSrc[BIT_W-1:0];
  assign curRow  = words[curWord];
  assign sumAny  = |sumBits;

  // lowest marked word not yet visited
  always_comb begin
    sumHit  = 1'b0;
    pickIdx = '0;
    for (int i = NUM_WORDS - 1; i >= 0; i--) begin
      if (sumBits[i] && (NXT_W'(i) >= nextWord)) begin
        sumHit  = 1'b1;
        pickIdx = WIDX_W'(i);
      end
    end
  end

  // lowest pending bit at or above scan position
  always_comb begin
    wordHit = 1'b0;
    hitBit  = '0;
    for (int b = WORD_BITS - 1; b >= 0; b--) begin
      if (curRow[b] && (BIT_W'(b) >= scanPos)) begin
        wordHit = 1'b1;
        hitBit  = BIT_W'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumBits <= '0;
      words   <= '0;
    end else begin
      if (strobe.pickWord) sumBits[pickIdx] <= 1'b0;
      if (strobe.takeBit)  words[curWord][hitBit] <= 1'b0;
      // a capture in the same cycle as a clear wins
      if (rejValid) begin
        sumBits[rejWord]        <= 1'b1;
        words[rejWord][rejBit]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextWord <= '0;
      curWord  <= '0;
      scanPos  <= '0;
      srcBit   <= '0;
    end else begin
      if (strobe.startScan) nextWord <= '0;
      if (strobe.pickWord) begin
        curWord  <= pickIdx;
        nextWord <= NXT_W'(pickIdx) + NXT_W'(1);
        scanPos  <= '0;
      end
      if (strobe.takeBit) srcBit <= hitBit;
      if (strobe.advance) scanPos <= srcBit + BIT_W'(1);
    end
  end

  assign lastBit  = (srcBit == BIT_W'(WORD_BITS - 1));
  assign retrySrc = {curWord, srcBit};

  assert_reject_marks_R1: assert property (@(posedge clk) disable iff (!rstN)
    rejValid |=> (sumBits[$past(rejWord)] && words[$past(rejWord)][$past(rejBit)]));

  assert_word_forward_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickWord |=> (NXT_W'(curWord) >= $past(nextWord)));

  assert_bit_forward_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeBit |=> (srcBit >= $past(scanPos)));

endmodule

// File: rtl/resend_ctrl.sv
module resend_ctrl
  import resend_scanner_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resendReq,
  input  logic        retryReady,
  input  logic        sumAny,
  input  logic        sumHit,
  input  logic        wordHit,
  input  logic        lastBit,
  output scanStrobe_t strobe,
  output logic        retryValid,
  output logic        scanDone
);

  scanState_e state, stateNxt;
  logic doneNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (resendReq) begin
          if (!sumAny) begin
            doneNxt = 1'b1;
          end else begin
            strobe.startScan = 1'b1;
            stateNxt = ST_PICK;
          end
        end
      end
      ST_PICK: begin
        if (sumHit) begin
          strobe.pickWord = 1'b1;
          stateNxt = ST_SCAN;
        end else begin
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (wordHit) begin
          strobe.takeBit = 1'b1;
          stateNxt = ST_ISSUE;
        end else begin
          stateNxt = ST_PICK;
        end
      end
      ST_ISSUE: begin
        if (retryReady) begin
          strobe.advance = 1'b1;
          stateNxt = lastBit ? ST_PICK : ST_SCAN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      scanDone <= 1'b0;
    end else begin
      state    <= stateNxt;
      scanDone <= doneNxt;
    end
  end

  assign retryValid = (state == ST_ISSUE);

  assert_empty_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && resendReq && !sumAny) |=> scanDone);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobe.startScan);

endmodule

// File: rtl/resend_scanner.sv
module resend_scanner
  import resend_scanner_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int SRC_W = $clog2(NUM_WORDS) + $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rejValid,
  input  logic [SRC_W-1:0] rejSrc,
  input  logic             resendReq,
  output logic             retryValid,
  input  logic             retryReady,
  output logic [SRC_W-1:0] retrySrc,
  output logic             retryIgnore,
  output logic             scanDone
);

  scanStrobe_t strobe;
  logic sumAny, sumHit, wordHit, lastBit;

  resend_bitmap #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_bitmap (
    .clk(clk), .rstN(rstN), .rejValid(rejValid), .rejSrc(rejSrc),
    .strobe(strobe), .sumAny(sumAny), .sumHit(sumHit), .wordHit(wordHit),
    .lastBit(lastBit), .retrySrc(retrySrc)
  );

  resend_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resendReq(resendReq), .retryReady(retryReady),
    .sumAny(sumAny), .sumHit(sumHit), .wordHit(wordHit), .lastBit(lastBit),
    .strobe(strobe), .retryValid(retryValid), .scanDone(scanDone)
  );

  assign retryIgnore = retryValid;

  // order tracking for the ascending-order property
  logic             haveLast;
  logic [SRC_W-1:0] lastSrc;
  always_ff @(posedge clk) begin
    if (!rstN || strobe.startScan) begin
      haveLast <= 1'b0;
      lastSrc  <= '0;
    end else if (retryValid && retryReady) begin
      haveLast <= 1'b1;
      lastSrc  <= retrySrc;
    end
  end

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rstN)
    (retryValid && retryReady && haveLast) |-> (retrySrc > lastSrc));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retryValid && !retryReady) |=> (retryValid && $stable(retrySrc)));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !retryValid);

endmodule

// File: tb/resend_scanner_tb.sv
module resend_scanner_tb;

  localparam int NSRC = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rejValid = 1'b0;
  logic [10:0] rejSrc = '0;
  logic        resendReq = 1'b0;
  logic        retryValid;
  logic        retryReady = 1'b0;
  logic [10:0] retrySrc;
  logic        retryIgnore;
  logic        scanDone;

  int checks = 0;
  int errors = 0;
  bit expBits [NSRC];
  bit deferred [NSRC];
  logic [7:0] lfsr = 8'h5a;

  always #5 clk = ~clk;

  resend_scanner u_dut (
    .clk(clk), .rstN(rstN), .rejValid(rejValid), .rejSrc(rejSrc),
    .resendReq(resendReq), .retryValid(retryValid), .retryReady(retryReady),
    .retrySrc(retrySrc), .retryIgnore(retryIgnore), .scanDone(scanDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one-cycle reject; caller sits at a negedge
  task automatic reject(input int src);
    rejValid = 1'b1;
    rejSrc   = 11'(src);
    expBits[src] = 1'b1;
    @(negedge clk);
    rejValid = 1'b0;
  endtask

  function automatic int remaining();
    int n = 0;
    for (int i = 0; i < NSRC; i++) n += expBits[i];
    return n;
  endfunction

  // run one resend; injAfter>0 injects a behind and an ahead reject after that many accepts
  task automatic doResend(input bit bp, input bit expectEmpty, input int injAfter,
                          input int behindSrc, input int aheadSrc, input string tag);
    int accepted = 0;
    int cyc = 0;
    int cursor = 0;
    bit done = 0;
    bit holdPend = 0;
    bit aheadPend = 0;
    logic [10:0] holdSrc = '0;
    resendReq = 1'b1;
    while (!done && cyc < 12000) begin
      @(negedge clk);
      cyc++;
      resendReq = 1'b0;
      rejValid  = 1'b0;
      if (holdPend) begin
        check(retryValid && retrySrc == holdSrc, "R6 hold", int'(retrySrc), int'(holdSrc));
        holdPend = 0;
      end
      if (aheadPend) begin
        rejValid = 1'b1; rejSrc = 11'(aheadSrc); expBits[aheadSrc] = 1'b1;
        aheadPend = 0;
      end
      if (scanDone) begin
        done = 1;
        if (expectEmpty) check(cyc == 1 && accepted == 0, "R2 empty done timing", cyc, 1);
        check(!retryValid, "R7 no retry with done", int'(retryValid), 0);
      end else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        retryReady = bp ? lfsr[0] : 1'b1;
        if (retryValid) begin
          check(retryIgnore, "R5 ignore flag", int'(retryIgnore), 1);
          if (retryReady) begin
            while (cursor < NSRC && !expBits[cursor]) cursor++;
            check(int'(retrySrc) == cursor, {"R3 ascending order ", tag}, int'(retrySrc), cursor);
            if (cursor < NSRC) expBits[cursor] = 1'b0;
            accepted++;
            if (accepted == injAfter) begin
              // behind the scan position: held; plus a mid-scan resend (R10)
              rejValid = 1'b1; rejSrc = 11'(behindSrc); deferred[behindSrc] = 1'b1;
              resendReq = 1'b1;
              aheadPend = 1;
            end
          end else begin
            holdPend = 1;
            holdSrc  = retrySrc;
          end
        end
      end
    end
    retryReady = 1'b0;
    rejValid = 1'b0;
    resendReq = 1'b0;
    check(done, {"R7 scan completes ", tag}, int'(done), 1);
    check(remaining() == 0, {"R1 all rejected sources retried ", tag}, remaining(), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!retryValid && !scanDone, "R10 quiet after done", int'(retryValid) + int'(scanDone), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!retryValid && !scanDone, "R2 reset state", int'(retryValid) + int'(scanDone), 0);

    // R2: nothing stored
    doResend(0, 1, 0, 0, 0, "empty");

    // R1 boundaries: first, last, word edge
    reject(0); reject(2047); reject(63); reject(64);
    doResend(0, 0, 0, 0, 0, "edges");
    // R4: replayed sources cleared
    doResend(0, 1, 0, 0, 0, "R4 after edges");

    // R9: duplicates
    reject(5); reject(5); reject(5); reject(700);
    doResend(1, 0, 0, 0, 0, "dup");
    doResend(0, 1, 0, 0, 0, "R4 after dup");

    // strided sweeps, alternating backpressure
    for (int s = 0; s < 5; s++) begin
      int stride;
      stride = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 64 : (s == 3) ? 65 : 127;
      for (int src = s; src < NSRC; src += stride) reject(src);
      doResend(s[0], 0, 0, 0, 0, "stride");
      doResend(0, 1, 0, 0, 0, "R4 after stride");
    end

    // R8: rejects during a scan
    reject(100); reject(500);
    doResend(1, 0, 1, 50, 700, "R8 mid-scan");
    for (int i = 0; i < NSRC; i++) begin
      expBits[i] = deferred[i];
      deferred[i] = 1'b0;
    end
    check(expBits[50] == 1'b1, "R8 behind held", int'(expBits[50]), 1);
    doResend(0, 0, 0, 0, 0, "R8 deferred replay");
    doResend(0, 1, 0, 0, 0, "R4 after R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule